// File: doc/BRIEF.md
# Partitioned Flash Command and Status Controller

This controller sits between a host command bus and a flash array split into sixteen equal partitions. Each partition remembers its own read source: array data, identifier data or the status word. Host writes on the command bus either change that read source for the addressed partition, clear the error flags, or open a two-write sequence that starts a program or an erase in the background. The program or erase is handed to an external write engine through a one-cycle start pulse and ends when the engine returns a done pulse.

Only one program or erase runs at a time. While it runs, a read request to any other partition is answered from that partition's own selected source. A read to the partition being written is always answered from status. A read request names a partition, and the answer comes back one cycle later. It carries the source to use, the partition it refers to, and a snapshot of the status word.

Top module: `rww_ctrl`

## Requirements
- R1: The partition of a command is `cmd_addr[21:18]` and the offset inside it is `cmd_addr[17:0]`. A read-source command changes only the partition it addresses.
- R2: Command codes sit in `cmd_data[7:0]`. 0xFF selects array reads (`rd_src`=0), 0x90 selects identifier reads (`rd_src`=1) and 0x70 selects status reads (`rd_src`=2). A read request with `rd_req`=1 and `rd_sel`=p is answered in the next cycle with `rd_valid`=1, `rd_part`=p, and `rd_src` equal to p's source.
- R3: Code 0x40 followed by any second write starts a program. In the cycle after the second write, `eng_start` is high for one cycle with `eng_op`=0. `eng_part` and `eng_addr` come from the second write's address, and `eng_data` is the second write's data.
- R4: Code 0x20 followed by 0xD0 starts an erase: `eng_start` pulses with `eng_op`=1, and `eng_part` and `eng_addr` come from the first write's address. Any second write other than 0xD0 starts nothing and sets status bit 1.
- R5: While a write is in progress, a 0x40 or 0x20 command starts nothing, opens no sequence and sets status bit 2. The write in progress ends on the first cycle where `eng_done` is sampled high.
- R6: While one partition is being written, reads of every other partition return that partition's own selected source.
- R7: A read of the partition being written returns source 2 (status), whatever source was selected for it.
- R8: When the write ends, its partition's source becomes status until a 0xFF command addresses it. A source command to that partition sampled on the same edge as `eng_done` takes precedence.
- R9: Code 0x50 clears status bits 2 and 1 and leaves bits 7 to 3 unchanged.
- R10: Status layout: bit 7 is 1 when no write is in progress. Bits 6:3 hold the partition of the most recently started write. Bit 2 is the rejected-write flag, bit 1 is the erase-sequence flag and bit 0 is 0. `rd_stat` is the status word as it stood when the read was sampled.
- R11: Reset puts every partition on array reads, drops any opened sequence and any write in progress, and clears status to 0x80.
- R12: Any code not listed above, written outside a sequence, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command bus write strobe |
| cmd_addr | input | 22 | Command address: partition and offset |
| cmd_data | input | 16 | Command code or program data |
| rd_req | input | 1 | Read request |
| rd_sel | input | 4 | Partition being read |
| rd_valid | output | 1 | Read answer valid |
| rd_src | output | 2 | Source for the answered read |
| rd_part | output | 4 | Partition the answer refers to |
| rd_stat | output | 8 | Status word snapshot |
| eng_start | output | 1 | One-cycle start pulse to the write engine |
| eng_op | output | 1 | 0 program, 1 erase |
| eng_part | output | 4 | Target partition |
| eng_addr | output | 18 | Target offset in the partition |
| eng_data | output | 16 | Program data |
| eng_done | input | 1 | Write engine completion pulse |

## Verification
Every result is due exactly one edge after the stimulus that causes it. A read answer appears after the edge that samples `rd_req`. The engine start pulse appears after the edge that samples the second command write. A source or status change caused by a command or by `eng_done` is seen by a read sampled on the following edge. The bench drives inputs 2 ns after a rising edge. It steps a behavioural model on each rising edge from the same sampled inputs and compares every output at the falling edge. Directed checks read outputs 2 ns after the edge that produced them.

// File: rtl/rww_pkg.sv
package rww_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_IDENT  = 2'd1,
    SRC_STATUS = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_PROG  = 2'd1,
    PEND_ERASE = 2'd2
  } pend_e;

  localparam logic [7:0] CODE_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CODE_RD_IDENT  = 8'h90;
  localparam logic [7:0] CODE_RD_STATUS = 8'h70;
  localparam logic [7:0] CODE_CLEAR     = 8'h50;
  localparam logic [7:0] CODE_PROG      = 8'h40;
  localparam logic [7:0] CODE_ERASE     = 8'h20;
  localparam logic [7:0] CODE_CONFIRM   = 8'hD0;

  // Map a command code onto a read source; valid only when is_src_code is true.
  function automatic src_e code_to_src(input logic [7:0] code);
    case (code)
      CODE_RD_IDENT:  return SRC_IDENT;
      CODE_RD_STATUS: return SRC_STATUS;
      default:        return SRC_ARRAY;
    endcase
  endfunction

  function automatic logic is_src_code(input logic [7:0] code);
    return (code == CODE_RD_ARRAY) || (code == CODE_RD_IDENT) ||
           (code == CODE_RD_STATUS);
  endfunction

endpackage

// File: rtl/rww_cmd_decode.sv
module rww_cmd_decode
  import rww_pkg::*;
(
  input  logic       cmd_we,
  input  pend_e      pend,
  input  logic [7:0] code,
  output logic       data_cycle,
  output logic       mode_evt,
  output src_e       mode_val,
  output logic       clr_evt,
  output logic       prog_setup,
  output logic       erase_setup
);

  logic idle_cmd;

  always_comb begin
    idle_cmd    = cmd_we && (pend == PEND_NONE);
    data_cycle  = cmd_we && (pend != PEND_NONE);
    mode_evt    = idle_cmd && is_src_code(code);
    mode_val    = code_to_src(code);
    clr_evt     = idle_cmd && (code == CODE_CLEAR);
    prog_setup  = idle_cmd && (code == CODE_PROG);
    erase_setup = idle_cmd && (code == CODE_ERASE);
  end

endmodule

// File: rtl/rww_mode_bank.sv
module rww_mode_bank
  import rww_pkg::*;
#(
  parameter int PART_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_evt,
  input  src_e              mode_val,
  input  logic [PART_W-1:0] cmd_part,
  input  logic              done_evt,
  input  logic [PART_W-1:0] done_part,
  input  logic [PART_W-1:0] rd_sel,
  output src_e              rd_mode
);

  localparam int NPART = 1 << PART_W;

  logic [2*NPART-1:0] mode_flat;

  for (genvar p = 0; p < NPART; p++) begin : g_part
    src_e m_q;
    // A user source command outranks the end-of-write return to status.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        m_q <= SRC_ARRAY;
      else if (mode_evt && (cmd_part == PART_W'(p)))
        m_q <= mode_val;
      else if (done_evt && (done_part == PART_W'(p)))
        m_q <= SRC_STATUS;
    end
    assign mode_flat[2*p +: 2] = m_q;
  end

  always_comb begin
    rd_mode = SRC_ARRAY;
    for (int p = 0; p < NPART; p++)
      if (rd_sel == PART_W'(p)) rd_mode = src_e'(mode_flat[2*p +: 2]);
  end

endmodule

// File: rtl/rww_write_seq.sv
module rww_write_seq
  import rww_pkg::*;
#(
  parameter int PART_W = 4,
  parameter int OFF_W  = 18,
  parameter int DATA_W = 16,
  parameter int STAT_W = PART_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_cycle,
  input  logic              prog_setup,
  input  logic              erase_setup,
  input  logic              clr_evt,
  input  logic [PART_W-1:0] cmd_part,
  input  logic [OFF_W-1:0]  cmd_off,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              eng_done,
  output pend_e             pend,
  output logic              busy,
  output logic [PART_W-1:0] busy_part,
  output logic              done_evt,
  output logic              rej_evt,
  output logic              seq_evt,
  output logic [STAT_W-1:0] status,
  output logic              eng_start,
  output logic              eng_op,
  output logic [PART_W-1:0] eng_part,
  output logic [OFF_W-1:0]  eng_addr,
  output logic [DATA_W-1:0] eng_data
);

  function automatic logic [STAT_W-1:0] pack_status(
    input logic rdy, input logic [PART_W-1:0] part,
    input logic rej, input logic seq);
    return {rdy, part, rej, seq, 1'b0};
  endfunction

  logic [PART_W-1:0] pend_part;
  logic [OFF_W-1:0]  pend_off;
  logic              err_rej, err_seq;
  logic              start_prog, start_erase, start_evt, confirm_ok;
  logic [PART_W-1:0] start_part;
  logic [OFF_W-1:0]  start_off;

  always_comb begin
    confirm_ok  = (cmd_data[7:0] == CODE_CONFIRM);
    start_prog  = data_cycle && (pend == PEND_PROG);
    start_erase = data_cycle && (pend == PEND_ERASE) && confirm_ok;
    seq_evt     = data_cycle && (pend == PEND_ERASE) && !confirm_ok;
    start_evt   = start_prog || start_erase;
    rej_evt     = (prog_setup || erase_setup) && busy;
    done_evt    = busy && eng_done;
    start_part  = start_prog ? cmd_part : pend_part;
    start_off   = start_prog ? cmd_off  : pend_off;
    status      = pack_status(!busy, busy_part, err_rej, err_seq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= PEND_NONE;
      pend_part <= '0;
      pend_off  <= '0;
      busy      <= 1'b0;
      busy_part <= '0;
      err_rej   <= 1'b0;
      err_seq   <= 1'b0;
      eng_start <= 1'b0;
      eng_op    <= 1'b0;
      eng_part  <= '0;
      eng_addr  <= '0;
      eng_data  <= '0;
    end else begin
      eng_start <= start_evt;
      if (data_cycle)
        pend <= PEND_NONE;
      else if (prog_setup && !busy)
        pend <= PEND_PROG;
      else if (erase_setup && !busy)
        pend <= PEND_ERASE;
      if ((prog_setup || erase_setup) && !busy) begin
        pend_part <= cmd_part;
        pend_off  <= cmd_off;
      end
      if (start_evt) begin
        busy      <= 1'b1;
        busy_part <= start_part;
        eng_op    <= start_erase;
        eng_part  <= start_part;
        eng_addr  <= start_off;
        eng_data  <= cmd_data;
      end else if (done_evt) begin
        busy <= 1'b0;
      end
      err_rej <= rej_evt || (err_rej && !clr_evt);
      err_seq <= seq_evt || (err_seq && !clr_evt);
    end
  end

endmodule

// File: rtl/rww_read_port.sv
module rww_read_port
  import rww_pkg::*;
#(
  parameter int PART_W = 4,
  parameter int STAT_W = PART_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [PART_W-1:0] rd_sel,
  input  src_e              rd_mode,
  input  logic              busy,
  input  logic [PART_W-1:0] busy_part,
  input  logic [STAT_W-1:0] status,
  output logic              rd_valid,
  output src_e              rd_src,
  output logic [PART_W-1:0] rd_part,
  output logic [STAT_W-1:0] rd_stat
);

  function automatic src_e pick_src(input src_e sel_mode, input logic hit_busy);
    return hit_busy ? SRC_STATUS : sel_mode;
  endfunction

  logic hit_busy;
  assign hit_busy = busy && (rd_sel == busy_part);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_src   <= SRC_ARRAY;
      rd_part  <= '0;
      rd_stat  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        rd_src  <= pick_src(rd_mode, hit_busy);
        rd_part <= rd_sel;
        rd_stat <= status;
      end
    end
  end

endmodule

// File: rtl/rww_ctrl.sv
module rww_ctrl
  import rww_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int PART_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_we,
  input  logic [ADDR_W-1:0]          cmd_addr,
  input  logic [DATA_W-1:0]          cmd_data,
  input  logic                       rd_req,
  input  logic [PART_W-1:0]          rd_sel,
  output logic                       rd_valid,
  output logic [1:0]                 rd_src,
  output logic [PART_W-1:0]          rd_part,
  output logic [PART_W+3:0]          rd_stat,
  output logic                       eng_start,
  output logic                       eng_op,
  output logic [PART_W-1:0]          eng_part,
  output logic [ADDR_W-PART_W-1:0]   eng_addr,
  output logic [DATA_W-1:0]          eng_data,
  input  logic                       eng_done
);

  localparam int OFF_W  = ADDR_W - PART_W;
  localparam int STAT_W = PART_W + 4;

  function automatic logic [PART_W-1:0] part_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: PART_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  // Named internal events, visible to the bound checker.
  pend_e             pend_w;
  logic              data_cycle, mode_evt, clr_evt, prog_setup, erase_setup;
  src_e              mode_val, rd_mode, rd_src_q;
  logic              busy_w, done_evt, rej_evt, seq_evt;
  logic [PART_W-1:0] busy_part_w, cmd_part_w;
  logic [STAT_W-1:0] status_w;

  assign cmd_part_w = part_of(cmd_addr);

  rww_cmd_decode u_dec (
    .cmd_we      (cmd_we),
    .pend        (pend_w),
    .code        (cmd_data[7:0]),
    .data_cycle  (data_cycle),
    .mode_evt    (mode_evt),
    .mode_val    (mode_val),
    .clr_evt     (clr_evt),
    .prog_setup  (prog_setup),
    .erase_setup (erase_setup)
  );

  rww_mode_bank #(.PART_W(PART_W)) u_modes (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_evt  (mode_evt),
    .mode_val  (mode_val),
    .cmd_part  (cmd_part_w),
    .done_evt  (done_evt),
    .done_part (busy_part_w),
    .rd_sel    (rd_sel),
    .rd_mode   (rd_mode)
  );

  rww_write_seq #(
    .PART_W(PART_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .STAT_W(STAT_W)
  ) u_wseq (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_cycle  (data_cycle),
    .prog_setup  (prog_setup),
    .erase_setup (erase_setup),
    .clr_evt     (clr_evt),
    .cmd_part    (cmd_part_w),
    .cmd_off     (off_of(cmd_addr)),
    .cmd_data    (cmd_data),
    .eng_done    (eng_done),
    .pend        (pend_w),
    .busy        (busy_w),
    .busy_part   (busy_part_w),
    .done_evt    (done_evt),
    .rej_evt     (rej_evt),
    .seq_evt     (seq_evt),
    .status      (status_w),
    .eng_start   (eng_start),
    .eng_op      (eng_op),
    .eng_part    (eng_part),
    .eng_addr    (eng_addr),
    .eng_data    (eng_data)
  );

  rww_read_port #(.PART_W(PART_W), .STAT_W(STAT_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_sel    (rd_sel),
    .rd_mode   (rd_mode),
    .busy      (busy_w),
    .busy_part (busy_part_w),
    .status    (status_w),
    .rd_valid  (rd_valid),
    .rd_src    (rd_src_q),
    .rd_part   (rd_part),
    .rd_stat   (rd_stat)
  );

  assign rd_src = rd_src_q;

endmodule

// File: rtl/rww_ctrl_chk.sv
module rww_ctrl_chk #(
  parameter int PART_W = 4,
  parameter int STAT_W = PART_W + 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic [PART_W-1:0] rd_sel,
  input logic              rd_valid,
  input logic [1:0]        rd_src,
  input logic              busy_w,
  input logic [PART_W-1:0] busy_part_w,
  input logic              eng_start,
  input logic              eng_done,
  input logic              rej_evt,
  input logic              seq_evt,
  input logic              clr_evt,
  input logic [STAT_W-1:0] status_w
);

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_seq_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_evt |=> (status_w[1] && !eng_start));

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !eng_done) |=> !eng_start);

  assert_reject_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rej_evt |=> (status_w[2] && !eng_start));

  assert_busy_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && busy_w && (rd_sel == busy_part_w)) |=> (rd_src == 2'd2));

  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && eng_done) |=> (!busy_w && status_w[STAT_W-1]));

  assert_clear_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (status_w[2:1] == 2'b00));

endmodule

bind rww_ctrl rww_ctrl_chk #(.PART_W(PART_W), .STAT_W(STAT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_req      (rd_req),
  .rd_sel      (rd_sel),
  .rd_valid    (rd_valid),
  .rd_src      (rd_src),
  .busy_w      (busy_w),
  .busy_part_w (busy_part_w),
  .eng_start   (eng_start),
  .eng_done    (eng_done),
  .rej_evt     (rej_evt),
  .seq_evt     (seq_evt),
  .clr_evt     (clr_evt),
  .status_w    (status_w)
);

// File: tb/rww_ctrl_test.sv
`timescale 1ns/1ps
module rww_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [21:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic        rd_req = 1'b0;
  logic [3:0]  rd_sel = '0;
  logic        rd_valid;
  logic [1:0]  rd_src;
  logic [3:0]  rd_part;
  logic [7:0]  rd_stat;
  logic        eng_start, eng_op;
  logic [3:0]  eng_part;
  logic [17:0] eng_addr;
  logic [15:0] eng_data;
  logic        eng_done = 1'b0;

  int checks = 0;
  int errors = 0;
  int eng_lat = 8;
  int eng_cnt = 0;

  always #5 clk = ~clk;

  rww_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rd_req(rd_req), .rd_sel(rd_sel),
    .rd_valid(rd_valid), .rd_src(rd_src), .rd_part(rd_part),
    .rd_stat(rd_stat), .eng_start(eng_start), .eng_op(eng_op),
    .eng_part(eng_part), .eng_addr(eng_addr), .eng_data(eng_data),
    .eng_done(eng_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_mode[16];
  int m_busy, m_bp, m_rej, m_seq, m_pend, m_ppart, m_poff;
  int e_valid, e_src, e_part, e_stat;
  int e_start, e_op, e_epart, e_addr, e_data;
  bit m_live = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mode[i]) m_mode[i] = 0;
      m_busy = 0; m_bp = 0; m_rej = 0; m_seq = 0; m_pend = 0;
      m_ppart = 0; m_poff = 0; e_valid = 0; e_start = 0;
      m_live = 1;
    end else begin
      int was_busy;
      int code;
      int p;
      was_busy = m_busy;
      e_valid = rd_req;
      if (rd_req) begin
        e_part = rd_sel;
        e_src  = (m_busy && rd_sel == m_bp) ? 2 : m_mode[rd_sel];
        e_stat = (m_busy ? 0 : 128) + m_bp * 8 + m_rej * 4 + m_seq * 2;
      end
      e_start = 0;
      if (m_busy && eng_done) begin
        m_busy = 0;
        m_mode[m_bp] = 2;
      end
      if (cmd_we) begin
        code = cmd_data[7:0];
        p = cmd_addr[21:18];
        if (m_pend == 1) begin
          e_start = 1; e_op = 0; e_epart = p; e_addr = cmd_addr[17:0];
          e_data = cmd_data; m_pend = 0;
        end else if (m_pend == 2) begin
          if (code == 'hD0) begin
            e_start = 1; e_op = 1; e_epart = m_ppart; e_addr = m_poff;
            e_data = cmd_data;
          end else m_seq = 1;
          m_pend = 0;
        end else begin
          case (code)
            'hFF: m_mode[p] = 0;
            'h90: m_mode[p] = 1;
            'h70: m_mode[p] = 2;
            'h50: begin m_rej = 0; m_seq = 0; end
            'h40, 'h20: begin
              if (was_busy) m_rej = 1;
              else begin
                m_pend = (code == 'h40) ? 1 : 2;
                m_ppart = p; m_poff = cmd_addr[17:0];
              end
            end
            default: ;
          endcase
        end
      end
      if (e_start) begin
        m_busy = 1;
        m_bp = e_epart;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_live) begin
      chk("R2 rd_valid model", rd_valid, e_valid);
      if (e_valid) begin
        chk("R2/R6/R7/R8 rd_src model", rd_src, e_src);
        chk("R1 rd_part model", rd_part, e_part);
        chk("R10 rd_stat model", rd_stat, e_stat);
      end
      chk("R3/R4/R5 eng_start model", eng_start, e_start);
      if (e_start) begin
        chk("R3/R4 eng_op model", eng_op, e_op);
        chk("R3/R4 eng_part model", eng_part, e_epart);
        chk("R3/R4 eng_addr model", eng_addr, e_addr);
        chk("R3 eng_data model", eng_data, e_data);
      end
    end
  end

  // ---------------- abstract write engine ----------------
  always @(negedge clk) begin
    if (!rst_n) begin
      eng_cnt = 0; eng_done = 1'b0;
    end else begin
      eng_done = 1'b0;
      if (eng_cnt > 0) begin
        eng_cnt--;
        if (eng_cnt == 0) eng_done = 1'b1;
      end
      if (eng_start) eng_cnt = eng_lat;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cmd(input logic [3:0] p, input logic [17:0] off, input logic [15:0] d);
    cmd_we = 1'b1; cmd_addr = {p, off}; cmd_data = d;
    @(posedge clk); #2;
    cmd_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] p);
    rd_req = 1'b1; rd_sel = p;
    @(posedge clk); #2;
    rd_req = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    do_reset();
    // R11: reset state
    rd(4'd3);
    chk("R11 reset source", rd_src, 0);
    chk("R11 reset status", rd_stat, 8'h80);
    chk("R11 no start after reset", eng_start, 0);

    // R1, R2: per-partition source selection
    cmd(4'd5, 18'h0, 16'h0090);
    cmd(4'd6, 18'h0, 16'h0070);
    rd(4'd5); chk("R2 ident source", rd_src, 1);
    chk("R2 read partition echo", rd_part, 5);
    rd(4'd6); chk("R2 status source", rd_src, 2);
    rd(4'd7); chk("R1 neighbour untouched", rd_src, 0);

    // R12: unknown code ignored
    cmd(4'd5, 18'h0, 16'h0033);
    rd(4'd5); chk("R12 unknown code no effect", rd_src, 1);
    chk("R12 status unchanged", rd_stat, 8'h80);

    // R3: program sequence
    eng_lat = 8;
    cmd(4'd2, 18'h0, 16'h0040);
    chk("R3 no start on setup", eng_start, 0);
    cmd(4'd2, 18'h00123, 16'hABCD);
    chk("R3 start pulse", eng_start, 1);
    chk("R3 op program", eng_op, 0);
    chk("R3 target partition", eng_part, 2);
    chk("R3 target offset", eng_addr, 18'h00123);
    chk("R3 data", eng_data, 16'hABCD);
    // R6, R7 during background write
    rd(4'd5); chk("R6 other partition keeps ident", rd_src, 1);
    rd(4'd2); chk("R7 busy partition reads status", rd_src, 2);
    chk("R10 busy status word", rd_stat, 8'h10);
    // R5: reject second write
    cmd(4'd9, 18'h0, 16'h0040);
    rd(4'd9); chk("R5 reject flag", rd_stat, 8'h14);
    chk("R5 no start while busy", eng_start, 0);
    chk("R5 rejected partition source", rd_src, 0);
    wait (eng_done); @(posedge clk); #2;
    // R8: status mode after completion
    rd(4'd2); chk("R8 status after write", rd_src, 2);
    chk("R10 ready status word", rd_stat, 8'h94);
    cmd(4'd2, 18'h0, 16'h00FF);
    rd(4'd2); chk("R8 array after 0xFF", rd_src, 0);

    // R4: erase sequence
    cmd(4'd11, 18'h2A000, 16'h0020);
    cmd(4'd0, 18'h00001, 16'h00D0);
    chk("R4 erase start", eng_start, 1);
    chk("R4 op erase", eng_op, 1);
    chk("R4 erase partition", eng_part, 11);
    chk("R4 erase offset", eng_addr, 18'h2A000);
    wait (eng_done); @(posedge clk); #2;
    rd(4'd11); chk("R8 erased partition status", rd_src, 2);
    cmd(4'd11, 18'h0, 16'h0020);
    cmd(4'd11, 18'h0, 16'h0077);
    chk("R4 bad confirm no start", eng_start, 0);
    rd(4'd0); chk("R4 sequence flag", rd_stat, 8'hDE);

    // R9: clear status
    cmd(4'd0, 18'h0, 16'h0050);
    rd(4'd0); chk("R9 flags cleared", rd_stat, 8'hD8);

    // R8: user command on the completion edge wins
    eng_lat = 3;
    cmd(4'd4, 18'h0, 16'h0040);
    cmd(4'd4, 18'h00010, 16'h5555);
    wait (eng_done);
    cmd_we = 1'b1; cmd_addr = {4'd4, 18'h0}; cmd_data = 16'h0090;
    @(posedge clk); #2 cmd_we = 1'b0;
    rd(4'd4); chk("R8 command beats completion", rd_src, 1);

    // R11: reset in mid-write and with an open sequence
    eng_lat = 20;
    cmd(4'd7, 18'h0, 16'h0040);
    cmd(4'd7, 18'h0, 16'h1111);
    do_reset();
    rd(4'd6); chk("R11 source cleared", rd_src, 0);
    chk("R11 write dropped", rd_stat, 8'h80);
    cmd(4'd8, 18'h0, 16'h0040);
    do_reset();
    cmd(4'd8, 18'h0, 16'h0034);
    chk("R11 sequence dropped", eng_start, 0);
    rd(4'd8); chk("R11 idle after reset", rd_stat, 8'h80);

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule